// File: doc/BRIEF.md
# LCD Segment Output Selector

This block produces the logic level for each segment line of a passive LCD from the two halves of a display latch, the internal common phase, and the state that says which of the two common lines is in its select interval. Every output bit stands for a drive rail: 1 is the high rail and 0 is the low rail. A lit segment is driven opposite to the common phase, so the panel sees a full-swing difference. A dark segment follows the common phase, so the panel sees no difference.

In static mode every segment takes its bit from latch half A. In half-duty dynamic mode the segment takes its bit from half A while common line A is selected, and from half B while common line B is selected. When the external-common select is high in static mode, the block works as a plain output expander. In that mode the external common input is a fixed polarity level rather than a toggling phase. Two test inputs override the latched data: one forces every segment lit and the other forces every segment dark, and the force-lit input wins. All outputs are registered, so the whole segment row changes on one clock edge together with the common phase.

Top module: `lcd_seg_selector`

## Requirements
- R1: While rst_n is low at a rising clock edge, every bit of seg_out is 0 after that edge.
- R2: seg_out is registered: a change on any input appears on seg_out only after the next rising clock edge, and not before it.
- R3: In static mode (mode_dyn=0, ext_com_sel=0), seg_out[n] = half_a[n] XOR com_phase, so a lit bit (1) is driven in antiphase to the common and a dark bit (0) is driven in phase with it.
- R4: In static mode half_b has no effect on seg_out.
- R5: In dynamic mode (mode_dyn=1) with sel_b=0 (common A selected), seg_out[n] = half_a[n] XOR com_phase.
- R6: In dynamic mode with sel_b=1 (common B selected), seg_out[n] = half_b[n] XOR com_phase. Bit n of half_b is overall display bit NUM_SEG+n.
- R7: With force_on=1, every segment behaves as lit: seg_out = NOT of the applied polarity on all bits, whatever the latch contents.
- R8: With force_off=1 and force_on=0, every segment behaves as dark: seg_out equals the applied polarity on all bits.
- R9: With force_on=1, force_off has no effect.
- R10: Releasing both overrides returns seg_out to the latched-data behaviour on the next clock edge.
- R11: In expander mode (mode_dyn=0, ext_com_sel=1) with ext_com_lvl=0, seg_out[n] = half_a[n], and com_phase has no effect.
- R12: In expander mode with ext_com_lvl=1, seg_out[n] = NOT half_a[n].
- R13: In dynamic mode, ext_com_sel and ext_com_lvl have no effect. Dynamic selection and com_phase stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_dyn | input | 1 | 1 = half-duty dynamic, 0 = static or expander |
| ext_com_sel | input | 1 | External-common select; in static mode picks expander behaviour |
| com_phase | input | 1 | Internal common phase level |
| sel_b | input | 1 | 1 = common B in select interval, 0 = common A |
| ext_com_lvl | input | 1 | External common level, used as fixed polarity in expander mode |
| half_a | input | NUM_SEG | Latch half A, bit n for segment n |
| half_b | input | NUM_SEG | Latch half B, bit n for segment n in the B interval |
| force_on | input | 1 | Test override: all segments lit (highest priority) |
| force_off | input | 1 | Test override: all segments dark |
| seg_out | output | NUM_SEG | Registered segment drive levels |

## Verification
The case hardest to reach from the ports is the common-B select interval while the overrides and the external-common inputs are also active. A fault in the half selection or in the priority logic only shows there. To get there, the stimulus loads half_a and half_b with complementary patterns, so that a wrong half choice inverts every bit. It then steps sel_b, com_phase and both overrides through their combinations. It also raises ext_com_sel during dynamic operation, so that a decoder which lets expander mode leak into dynamic mode changes the outputs.

// File: rtl/lcd_seg_pkg.sv
// Package: shared types for the LCD segment output selector.
// Assumes: nothing beyond the standard language.
package lcd_seg_pkg;

    // Operating behaviour of the segment row
    typedef enum logic [1:0] {
        MODE_STATIC  = 2'd0,
        MODE_DYNAMIC = 2'd1,
        MODE_EXPAND  = 2'd2
    } seg_mode_e;

    // Active test override after priority resolution
    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_LIT  = 2'd1,
        OVR_DARK = 2'd2
    } seg_ovr_e;

endpackage

// File: rtl/lcd_mode_decode.sv
// Module: lcd_mode_decode
// Decodes the operating mode, the polarity applied to all segments and the
// resolved test override. Dynamic mode takes precedence over the external
// common select; the lit override takes precedence over the dark one.
// Assumes: all inputs are synchronous to the system clock.
module lcd_mode_decode
    import lcd_seg_pkg::*;
(
    input  logic      mode_dyn,
    input  logic      ext_com_sel,
    input  logic      com_phase,
    input  logic      ext_com_lvl,
    input  logic      force_on,
    input  logic      force_off,
    output seg_mode_e mode,
    output logic      polarity,
    output seg_ovr_e  ovr
);

    // Select the operating mode from the two mode pins
    always_comb begin
        if (mode_dyn)
            mode = MODE_DYNAMIC;
        else if (ext_com_sel)
            mode = MODE_EXPAND;
        else
            mode = MODE_STATIC;
    end

    // Pick the polarity: fixed level in expander mode, toggling phase otherwise
    always_comb begin
        if (mode == MODE_EXPAND)
            polarity = ext_com_lvl;
        else
            polarity = com_phase;
    end

    // Resolve the two test overrides with a fixed priority
    always_comb begin
        if (force_on)
            ovr = OVR_LIT;
        else if (force_off)
            ovr = OVR_DARK;
        else
            ovr = OVR_NONE;
    end

endmodule

// File: rtl/lcd_half_pick.sv
// Module: lcd_half_pick
// Chooses per segment the latch half that feeds it: half B only in dynamic
// mode during the common-B select interval, half A in every other case.
// Assumes: sel_b is aligned with the common phase it belongs to.
module lcd_half_pick
    import lcd_seg_pkg::*;
#(
    parameter int NUM_SEG = 80
) (
    input  seg_mode_e          mode,
    input  logic               sel_b,
    input  logic [NUM_SEG-1:0] half_a,
    input  logic [NUM_SEG-1:0] half_b,
    output logic [NUM_SEG-1:0] data
);

    logic use_b;

    // Decide once whether the B half is in use this cycle
    always_comb begin
        use_b = (mode == MODE_DYNAMIC) && sel_b;
    end

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_pick
        // Per-segment two-way half selection
        always_comb begin
            data[g] = use_b ? half_b[g] : half_a[g];
        end
    end

endmodule

// File: rtl/lcd_override.sv
// Module: lcd_override
// Replaces the selected data with all-lit or all-dark when a test override
// is active; passes the data through untouched otherwise.
// Assumes: ovr is already priority-resolved.
module lcd_override
    import lcd_seg_pkg::*;
#(
    parameter int NUM_SEG = 80
) (
    input  seg_ovr_e           ovr,
    input  logic [NUM_SEG-1:0] data_in,
    output logic [NUM_SEG-1:0] data_out
);

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ovr
        // Per-segment override application
        always_comb begin
            unique case (ovr)
                OVR_LIT:  data_out[g] = 1'b1;
                OVR_DARK: data_out[g] = 1'b0;
                default:  data_out[g] = data_in[g];
            endcase
        end
    end

endmodule

// File: rtl/lcd_seg_drive.sv
// Module: lcd_seg_drive
// Combines each data bit with the shared polarity (lit = opposite of the
// polarity, dark = equal to it) and registers the whole row.
// Assumes: synchronous active-low reset; outputs clear to the low rail.
module lcd_seg_drive #(
    parameter int NUM_SEG = 80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEG-1:0] data,
    input  logic               polarity,
    output logic [NUM_SEG-1:0] seg_q
);

    logic [NUM_SEG-1:0] seg_d;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_level
        // Per-segment level relative to the common polarity
        always_comb begin
            seg_d[g] = data[g] ^ polarity;
        end
    end

    // Register the full segment row on one edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            seg_q <= '0;
        else
            seg_q <= seg_d;
    end

endmodule

// File: rtl/lcd_seg_selector.sv
// Module: lcd_seg_selector (top)
// Produces the registered segment drive levels of an LCD row from two latch
// halves, the common phase and the common select state, with static,
// half-duty dynamic and output-expander behaviour plus two test overrides.
// Assumes: latch, common generation and analog drive live outside.
module lcd_seg_selector
    import lcd_seg_pkg::*;
#(
    parameter int NUM_SEG = 80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_dyn,
    input  logic               ext_com_sel,
    input  logic               com_phase,
    input  logic               sel_b,
    input  logic               ext_com_lvl,
    input  logic [NUM_SEG-1:0] half_a,
    input  logic [NUM_SEG-1:0] half_b,
    input  logic               force_on,
    input  logic               force_off,
    output logic [NUM_SEG-1:0] seg_out
);

    seg_mode_e          mode;
    seg_ovr_e           ovr;
    logic               polarity;
    logic [NUM_SEG-1:0] picked;
    logic [NUM_SEG-1:0] final_data;

    lcd_mode_decode u_decode (
        .mode_dyn    (mode_dyn),
        .ext_com_sel (ext_com_sel),
        .com_phase   (com_phase),
        .ext_com_lvl (ext_com_lvl),
        .force_on    (force_on),
        .force_off   (force_off),
        .mode        (mode),
        .polarity    (polarity),
        .ovr         (ovr)
    );

    lcd_half_pick #(.NUM_SEG(NUM_SEG)) u_pick (
        .mode   (mode),
        .sel_b  (sel_b),
        .half_a (half_a),
        .half_b (half_b),
        .data   (picked)
    );

    lcd_override #(.NUM_SEG(NUM_SEG)) u_ovr (
        .ovr      (ovr),
        .data_in  (picked),
        .data_out (final_data)
    );

    lcd_seg_drive #(.NUM_SEG(NUM_SEG)) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .data     (final_data),
        .polarity (polarity),
        .seg_q    (seg_out)
    );

endmodule

// File: rtl/lcd_seg_selector_chk.sv
// Module: lcd_seg_selector_chk
// Checker bound to the top: relates the registered segment row to the
// inputs of the previous cycle for each mode and override.
module lcd_seg_selector_chk #(
    parameter int NUM_SEG = 80
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mode_dyn,
    input logic               ext_com_sel,
    input logic               com_phase,
    input logic               sel_b,
    input logic               ext_com_lvl,
    input logic [NUM_SEG-1:0] half_a,
    input logic [NUM_SEG-1:0] half_b,
    input logic               force_on,
    input logic               force_off,
    input logic [NUM_SEG-1:0] seg_out
);

    logic quiet;
    assign quiet = !force_on && !force_off;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> seg_out == '0);

    assert_static_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dyn && !ext_com_sel && quiet) |=>
        seg_out == ($past(half_a) ^ {NUM_SEG{$past(com_phase)}}));

    assert_dyn_half_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dyn && !sel_b && quiet) |=>
        seg_out == ($past(half_a) ^ {NUM_SEG{$past(com_phase)}}));

    assert_dyn_half_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dyn && sel_b && quiet) |=>
        seg_out == ($past(half_b) ^ {NUM_SEG{$past(com_phase)}}));

    assert_force_lit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_on && (mode_dyn || !ext_com_sel)) |=>
        seg_out == {NUM_SEG{!$past(com_phase)}});

    assert_force_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_off && !force_on && (mode_dyn || !ext_com_sel)) |=>
        seg_out == {NUM_SEG{$past(com_phase)}});

    assert_expander_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dyn && ext_com_sel && quiet) |=>
        seg_out == ($past(half_a) ^ {NUM_SEG{$past(ext_com_lvl)}}));

endmodule

bind lcd_seg_selector lcd_seg_selector_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_dyn    (mode_dyn),
    .ext_com_sel (ext_com_sel),
    .com_phase   (com_phase),
    .sel_b       (sel_b),
    .ext_com_lvl (ext_com_lvl),
    .half_a      (half_a),
    .half_b      (half_b),
    .force_on    (force_on),
    .force_off   (force_off),
    .seg_out     (seg_out)
);

// File: tb/test_lcd_seg_selector.sv
module test_lcd_seg_selector;

    localparam int  NUM_SEG    = 80;
    localparam time CLK_PERIOD = 10ns;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               mode_dyn, ext_com_sel, com_phase, sel_b, ext_com_lvl;
    logic [NUM_SEG-1:0] half_a, half_b;
    logic               force_on, force_off;
    logic [NUM_SEG-1:0] seg_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [NUM_SEG-1:0] exp_q[$];
    string              tag_q[$];
    logic [NUM_SEG-1:0] last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_seg_selector #(.NUM_SEG(NUM_SEG)) i_lcd_seg_selector (
        .clk(clk), .rst_n(rst_n), .mode_dyn(mode_dyn), .ext_com_sel(ext_com_sel),
        .com_phase(com_phase), .sel_b(sel_b), .ext_com_lvl(ext_com_lvl),
        .half_a(half_a), .half_b(half_b), .force_on(force_on),
        .force_off(force_off), .seg_out(seg_out)
    );

    // Expected row from the requirements
    function automatic logic [NUM_SEG-1:0] model(
        logic dyn, logic ext, logic ph, logic sb, logic lvl,
        logic [NUM_SEG-1:0] a, logic [NUM_SEG-1:0] b, logic fon, logic foff);
        logic [NUM_SEG-1:0] d;
        logic pol;
        d   = (dyn && sb) ? b : a;          // R5 R6, R3 R4
        if (fon)       d = '1;              // R7 R9
        else if (foff) d = '0;              // R8
        pol = (!dyn && ext) ? lvl : ph;     // R11 R12 R13
        return d ^ {NUM_SEG{pol}};
    endfunction

    task automatic compare(string tag, logic [NUM_SEG-1:0] act, logic [NUM_SEG-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue its expected row
    task automatic drive(string tag, logic dyn, logic ext, logic ph, logic sb,
                         logic lvl, logic [NUM_SEG-1:0] a, logic [NUM_SEG-1:0] b,
                         logic fon, logic foff);
        @(negedge clk);
        mode_dyn = dyn; ext_com_sel = ext; com_phase = ph; sel_b = sb;
        ext_com_lvl = lvl; half_a = a; half_b = b; force_on = fon; force_off = foff;
        exp_q.push_back(model(dyn, ext, ph, sb, lvl, a, b, fon, foff));
        tag_q.push_back(tag);
    endtask

    // Monitor: pop and compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                last_exp = exp_q.pop_front();
                compare(tag_q.pop_front(), seg_out, last_exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [NUM_SEG-1:0] pa, pb, pc;
        pa = {5{16'hC3A5}};
        pb = ~pa;
        pc = {5{16'h0F96}};
        rst_n = 1'b0; mode_dyn = 0; ext_com_sel = 0; com_phase = 1; sel_b = 0;
        ext_com_lvl = 0; half_a = pa; half_b = pb; force_on = 0; force_off = 0;
        repeat (3) @(posedge clk);
        #1 compare("R1 reset clear", seg_out, '0);
        @(negedge clk) rst_n = 1'b1;

        // R3 static, both phases; R4 half_b varies with no effect
        drive("R3 static ph0", 0,0,0,0,0, pa, pb, 0,0);
        drive("R3 static ph1", 0,0,1,0,0, pa, pb, 0,0);
        drive("R4 static halfb ignored", 0,0,1,0,0, pa, pc, 0,0);
        drive("R4 static selb ignored", 0,0,1,1,0, pa, '1, 0,0);
        for (int k = 0; k < NUM_SEG; k += 19)
            drive("R3 static walking bit", 0,0,k[0],0,0, {{(NUM_SEG-1){1'b0}},1'b1} << k, pb, 0,0);

        // R2 latency: change input, output must hold until the edge
        drive("R2 settle", 0,0,0,0,0, pa, pb, 0,0);
        @(negedge clk);
        half_a = pc; com_phase = 1'b1;
        #1 compare("R2 no change before edge", seg_out, model(0,0,0,0,0,pa,pb,0,0));
        exp_q.push_back(model(0,0,1,0,0,pc,pb,0,0));
        tag_q.push_back("R2 change after edge");

        // R5 R6 dynamic across the common intervals
        drive("R5 dyn A ph0", 1,0,0,0,0, pa, pb, 0,0);
        drive("R5 dyn A ph1", 1,0,1,0,0, pa, pb, 0,0);
        drive("R6 dyn B ph0", 1,0,0,1,0, pa, pb, 0,0);
        drive("R6 dyn B ph1", 1,0,1,1,0, pa, pc, 0,0);
        // R13 external common inputs ignored in dynamic mode
        drive("R13 dyn ext ignored A", 1,1,0,0,1, pa, pb, 0,0);
        drive("R13 dyn ext ignored B", 1,1,1,1,0, pa, pb, 0,0);

        // R7 R8 R9 R10 overrides
        drive("R7 force lit static", 0,0,1,0,0, pa, pb, 1,0);
        drive("R7 force lit dyn B", 1,0,0,1,0, pa, pb, 1,0);
        drive("R8 force dark static", 0,0,0,0,0, pa, pb, 0,1);
        drive("R8 force dark dyn", 1,0,1,1,0, pa, pb, 0,1);
        drive("R9 lit beats dark", 0,0,1,0,0, pa, pb, 1,1);
        drive("R9 lit beats dark dyn", 1,0,0,1,0, '0, '0, 1,1);
        drive("R10 release restores", 1,0,0,1,0, pa, pb, 0,0);
        drive("R10 release static", 0,0,1,0,0, pa, pb, 0,0);

        // R11 R12 expander
        drive("R11 expander lvl0", 0,1,0,0,0, pa, pb, 0,0);
        drive("R11 expander phase ignored", 0,1,1,1,0, pa, pb, 0,0);
        drive("R12 expander lvl1", 0,1,0,0,1, pa, pb, 0,0);
        drive("R12 expander lvl1 other data", 0,1,1,0,1, pc, pb, 0,0);
        drive("R7 force lit expander", 0,1,0,0,1, pa, pb, 1,0);

        // R1 reset again mid-run
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 compare("R1 reset mid-run", seg_out, '0);

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule